// File: doc/BRIEF.md
# Subtract-and-Branch Processor Core

This block is a small multicycle processor that has exactly one instruction. Each instruction subtracts one memory word from another, writes the difference back, and branches when that difference is zero or negative. No opcode is decoded. Every 24-bit word fetched as an instruction is read as three packed 8-bit addresses.

The core drives a synchronous single-port RAM of 256 words of 24 bits. The RAM has a one-cycle read latency and holds both the program and its data. Its contents are preloaded before reset is released, and the core has no other input. Output is memory mapped: any write-back to address 100 is also latched into an output register that feeds a display.

Each instruction runs through a fixed sequence of eight cycles:

1. Present the program counter.
2. Capture the instruction word.
3. Present operand A.
4. Capture mem[A].
5. Present operand B.
6. Capture mem[B].
7. Write back the difference.
8. Update the program counter.

Top module: `sbz_core`

## Requirements
- R1: An instruction word holds operand A in bits [23:16], operand B in bits [15:8] and the branch target C in bits [7:0]. The write-back goes to address B.
- R2: The value written back is mem[B] − mem[A], taken modulo 2^24 (24-bit two's complement).
- R3: When the written value is zero or has bit 23 set, the next instruction is fetched from address C.
- R4: Otherwise the next fetch address is PC + 1 modulo 256, so address 255 is followed by address 0.
- R5: Every instruction takes exactly 8 cycles. Counting the cycle that presents the fetch address as cycle 0, the single memory write occurs in cycle 6, and cycle 8 presents the next fetch address. No other cycle writes memory.
- R6: A write to address 100 is captured into `out_value` and appears one cycle after the write cycle. Writes to any other address leave `out_value` unchanged.
- R7: A synchronous reset clears the program counter and the output register. The first cycle after reset presents fetch address 0, with no write.
- R8: An instruction whose result is ≤ 0 and whose C equals its own address repeats forever. It writes the same location once every 8 cycles, and acts as a halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | RAM address, driven from the memory address register |
| mem_we | output | 1 | RAM write enable, high only in the write-back cycle |
| mem_wdata | output | 24 | Difference written back to address B |
| mem_rdata | input | 24 | RAM read data, valid one cycle after the address |
| out_value | output | 24 | Output register, loaded by writes to address 100 |

## Verification
The assertions hold on every cycle for the following properties:

- The strobe order between write-back, PC update and fetch.
- The write address equals field B of the held instruction.
- The PC and the flag move only in their own states.
- The output register changes only on a write to address 100, and then takes the written data.

Only the bench scenarios can show that the arithmetic is correct across the sign boundary and at the extremes of the 24-bit range. The same is true of the branch decision for zero and negative results, the PC wrapping from 255 to 0, and the halt idiom repeating indefinitely. The bench shows these by replaying each program in its own instruction-level model.

// File: rtl/sbz_pkg.sv
package sbz_pkg;

  // Eight phases of one instruction; one memory access per phase at most.
  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,  // present PC on the address bus
    ST_IR    = 3'd1,  // capture instruction word, aim MAR at A
    ST_RDA   = 3'd2,  // present A
    ST_LDA   = 3'd3,  // capture mem[A], aim MAR at B
    ST_RDB   = 3'd4,  // present B
    ST_LDB   = 3'd5,  // capture mem[B]
    ST_WB    = 3'd6,  // write difference to B, record flag
    ST_PC    = 3'd7   // choose next PC, aim MAR at it
  } sbz_state_e;

endpackage

// File: rtl/sbz_seq.sv
module sbz_seq
  import sbz_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic ir_ld,
  output logic opa_ld,
  output logic opb_ld,
  output logic wb_fire,
  output logic pc_ld
);

  sbz_state_e state_q;
  sbz_state_e state_d;

  always_comb begin
    case (state_q)
      ST_FETCH: state_d = ST_IR;
      ST_IR:    state_d = ST_RDA;
      ST_RDA:   state_d = ST_LDA;
      ST_LDA:   state_d = ST_RDB;
      ST_RDB:   state_d = ST_LDB;
      ST_LDB:   state_d = ST_WB;
      ST_WB:    state_d = ST_PC;
      default:  state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH;
    else     state_q <= state_d;
  end

  assign ir_ld   = (state_q == ST_IR);
  assign opa_ld  = (state_q == ST_LDA);
  assign opb_ld  = (state_q == ST_LDB);
  assign wb_fire = (state_q == ST_WB);
  assign pc_ld   = (state_q == ST_PC);

  AST_WB_THEN_PC: assert property (@(posedge clk) disable iff (rst)
    wb_fire |=> pc_ld); // R5
  AST_PC_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
    pc_ld |=> (state_q == ST_FETCH)); // R5
  AST_LDB_THEN_WB: assert property (@(posedge clk) disable iff (rst)
    opb_ld |=> wb_fire); // R5

endmodule

// File: rtl/sbz_datapath.sv
module sbz_datapath #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ir_ld,
  input  logic              opa_ld,
  input  logic              opb_ld,
  input  logic              wb_fire,
  input  logic              pc_ld,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam int HI_A = DATA_W - 1;
  localparam int HI_B = 2 * ADDR_W - 1;
  localparam int HI_C = ADDR_W - 1;

  // Field extraction from a packed instruction word.
  function automatic logic [ADDR_W-1:0] f_field_a(input logic [DATA_W-1:0] w);
    return w[HI_A -: ADDR_W];
  endfunction

  function automatic logic [ADDR_W-1:0] f_field_b(input logic [DATA_W-1:0] w);
    return w[HI_B -: ADDR_W];
  endfunction

  function automatic logic [ADDR_W-1:0] f_field_c(input logic [DATA_W-1:0] w);
    return w[HI_C -: ADDR_W];
  endfunction

  // Modular difference and the "not greater than zero" test.
  function automatic logic [DATA_W-1:0] f_diff(input logic [DATA_W-1:0] minuend,
                                               input logic [DATA_W-1:0] subtrahend);
    return minuend - subtrahend;
  endfunction

  function automatic logic f_le_zero(input logic [DATA_W-1:0] v);
    return (v == '0) || v[DATA_W-1];
  endfunction

  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] opa_q;
  logic [DATA_W-1:0] opb_q;
  logic [ADDR_W-1:0] mar_q;
  logic [ADDR_W-1:0] pc_q;
  logic              flag_q;

  logic [DATA_W-1:0] diff;
  logic [ADDR_W-1:0] pc_seq;
  logic [ADDR_W-1:0] pc_next;

  assign diff    = f_diff(opb_q, opa_q);
  assign pc_seq  = pc_q + ADDR_W'(1);
  assign pc_next = flag_q ? f_field_c(ir_q) : pc_seq;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= '0;
    end else if (ir_ld) begin
      ir_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opa_q <= '0;
      opb_q <= '0;
    end else begin
      if (opa_ld) opa_q <= mem_rdata;
      if (opb_ld) opb_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q <= '0;
    end else if (ir_ld) begin
      mar_q <= f_field_a(mem_rdata);
    end else if (opa_ld) begin
      mar_q <= f_field_b(ir_q);
    end else if (pc_ld) begin
      mar_q <= pc_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (wb_fire) begin
      flag_q <= f_le_zero(diff);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (pc_ld) begin
      pc_q <= pc_next;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_we    = wb_fire;
  assign mem_wdata = diff;

  AST_WB_TARGET: assert property (@(posedge clk) disable iff (rst)
    wb_fire |-> (mar_q == f_field_b(ir_q))); // R1
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wb_fire |=> $stable(flag_q)); // R3
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pc_ld |=> $stable(pc_q)); // R4
  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (rst)
    pc_ld |=> (mar_q == pc_q)); // R5
  AST_RESET_ORIGIN: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && mar_q == '0)); // R7

endmodule

// File: rtl/sbz_out_latch.sv
module sbz_out_latch #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 24,
  parameter int OUT_ADDR = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] out_value
);

  localparam logic [ADDR_W-1:0] OUT_A = ADDR_W'(OUT_ADDR);

  logic              hit;
  logic [DATA_W-1:0] out_q;

  assign hit = wr_en && (wr_addr == OUT_A);

  always_ff @(posedge clk) begin
    if (rst)      out_q <= '0;
    else if (hit) out_q <= wr_data;
  end

  assign out_value = out_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(out_q)); // R6
  AST_OUT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    hit |=> (out_q == $past(wr_data))); // R6
  AST_OUT_RESET: assert property (@(posedge clk)
    rst |=> (out_q == '0)); // R7

endmodule

// File: rtl/sbz_core.sv
module sbz_core #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 24,
  parameter int OUT_ADDR = 100
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] out_value
);

  logic ir_ld;
  logic opa_ld;
  logic opb_ld;
  logic wb_fire;
  logic pc_ld;

  sbz_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .ir_ld   (ir_ld),
    .opa_ld  (opa_ld),
    .opb_ld  (opb_ld),
    .wb_fire (wb_fire),
    .pc_ld   (pc_ld)
  );

  sbz_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ir_ld     (ir_ld),
    .opa_ld    (opa_ld),
    .opb_ld    (opb_ld),
    .wb_fire   (wb_fire),
    .pc_ld     (pc_ld),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
  );

  sbz_out_latch #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .OUT_ADDR (OUT_ADDR)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (mem_we),
    .wr_addr   (mem_addr),
    .wr_data   (mem_wdata),
    .out_value (out_value)
  );

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R5

endmodule

// File: tb/test_sbz_core.sv
`timescale 1ns/1ps
module test_sbz_core;

  localparam int AW    = 8;
  localparam int DW    = 24;
  localparam int OUT_A = 100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] out_value;

  logic [DW-1:0] ram     [0:255];
  logic [DW-1:0] ref_mem [0:255];
  logic [AW-1:0] ref_pc;
  logic [DW-1:0] ref_out;
  string         pc_tag;
  int            n_tests = 0;
  int            n_fail  = 0;
  bit            done    = 1'b0;

  logic [DW-1:0] vals [8] = '{24'h000000, 24'h000001, 24'h000002, 24'hFFFFFF,
                              24'hFFFFFE, 24'h7FFFFF, 24'h800000, 24'h123456};

  always #4 clk = ~clk;  // 125 MHz

  sbz_core #(.ADDR_W(AW), .DATA_W(DW), .OUT_ADDR(OUT_A)) i_sbz_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .out_value (out_value)
  );

  // Synchronous single-port RAM model, one-cycle read latency.
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input int a, input int b, input int c);
    return {AW'(a), AW'(b), AW'(c)};
  endfunction

  task automatic put(input int addr, input logic [DW-1:0] v);
    ram[addr]     = v;
    ref_mem[addr] = v;
  endtask

  // Hold reset and wipe both memories; caller then loads a program.
  task automatic enter_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 256; k++) begin
      ram[k]     = '0;
      ref_mem[k] = '0;
    end
  endtask

  task automatic leave_reset();
    @(negedge clk);
    rst     = 1'b0;
    ref_pc  = '0;
    ref_out = '0;
    pc_tag  = "R7";
    chk("R7", "fetch address after reset", 32'(mem_addr), 32'h0);
    chk("R7", "output after reset", 32'(out_value), 32'h0);
    chk("R7", "no write after reset", 32'(mem_we), 32'h0);
  endtask

  // Execute n instructions, comparing each against the instruction model.
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] w;
      logic [AW-1:0] fa, fb, fc, old_pc;
      logic [DW-1:0] d;
      bit            taken;
      chk(pc_tag, "fetch address", 32'(mem_addr), 32'(ref_pc));
      w      = ref_mem[ref_pc];
      fa     = w[23:16];
      fb     = w[15:8];
      fc     = w[7:0];
      old_pc = ref_pc;
      d      = ref_mem[fb] - ref_mem[fa];
      repeat (6) @(negedge clk);
      chk("R5", "write strobe in cycle 6", 32'(mem_we), 32'h1);
      chk("R1", "write address is field B", 32'(mem_addr), 32'(fb));
      chk("R2", "written difference", 32'(mem_wdata), 32'(d));
      ref_mem[fb] = d;
      if (fb == AW'(OUT_A)) ref_out = d;
      taken  = (d == '0) || d[DW-1];
      ref_pc = taken ? fc : old_pc + AW'(1);
      if (taken && fc == old_pc) pc_tag = "R8";
      else if (taken)            pc_tag = "R3";
      else                       pc_tag = "R4";
      @(negedge clk);
      chk("R6", "output register", 32'(out_value), 32'(ref_out));
      chk("R5", "no write in cycle 7", 32'(mem_we), 32'h0);
      @(negedge clk);
    end
    chk(pc_tag, "final fetch address", 32'(mem_addr), 32'(ref_pc));
  endtask

  initial begin
    // Sweep of operand pairs; odd columns target the output address.
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        int b;
        b = (j % 2 == 1) ? OUT_A : 41;
        enter_reset();
        put(0, ins(40, b, 8'h77));
        put(40, vals[i]);
        put(b, vals[j]);
        leave_reset();
        run(2);
      end
    end

    // PC wrap: branch to 255, then a positive result falls through to 0 (R4).
    enter_reset();
    put(0, ins(50, 50, 255));
    put(255, ins(51, 52, 9));
    put(51, 24'h000001);
    put(52, 24'h000005);
    leave_reset();
    run(4);

    // Halt idiom: self-branch on a zero location repeats (R8).
    enter_reset();
    put(0, ins(60, 61, 3));
    put(1, ins(62, 62, 1));
    put(60, 24'hFFFFFD);
    put(61, 24'h000000);
    leave_reset();
    run(6);

    // Counting loop on the output address, with a non-output write in between (R6).
    enter_reset();
    put(0, ins(20, OUT_A, 1));
    put(1, ins(21, 21, 0));
    put(20, 24'hFFFFFF);
    leave_reset();
    run(20);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule